// File: doc/BRIEF.md
# Bus Clock Divider and Gating

This block runs on a fast master clock and produces three synchronous clock enables: a base (system bus) enable, a peripheral bus enable and a trace enable. Each enable is a single-cycle pulse, one per divided period. The base enable divides the master clock. The peripheral and trace enables each divide the base enable by their own ratio, so they always pulse on a master cycle in which the base enable also pulses. Downstream logic qualifies its flops with these enables instead of using separate clock trees.

Software writes the three ratio codes and a peripheral-bus stop bit through a small register write port. The port has a 2-bit address and 3-bit data. Two low-power mode inputs, timer mode and stop mode, stop the peripheral and trace enables while either is high. The base enable keeps running in those modes. A ratio change never shortens a period: the interval in progress finishes at the old ratio. After a stop is released, the divider counts a full new period before its first pulse.

Top module: `busclk_gen`

## Requirements
- R1: After reset, every ratio is 1 and the peripheral stop bit is clear, so base_en, pbus_en and trace_en are high on every master clock cycle.
- R2: Address 0, data bits [2:0], holds the base ratio code. Codes 0, 1, 2, 3 and 4 give a base_en period of 1, 2, 4, 8 and 16 master cycles.
- R3: Base ratio codes 5, 6 and 7 saturate to a period of 16 master cycles.
- R4: Address 1, data bits [2:0], holds the peripheral ratio code. Codes 0 to 3 make pbus_en pulse once every 1, 2, 4 or 8 base_en pulses. Codes 4 to 7 saturate to 8.
- R5: Address 2, data bits [2:0], holds the trace ratio code. Code 0 makes trace_en pulse on every base_en pulse. Code 1 and every larger code make it pulse on every second base_en pulse.
- R6: pbus_en and trace_en are only ever high in a cycle in which base_en is high.
- R7: While lp_timer or lp_stop is high (sampled by one register), pbus_en and trace_en stay low and base_en keeps pulsing.
- R8: Address 3, data bit 0, is the peripheral stop bit. A value of 1 holds pbus_en low and leaves trace_en unaffected.
- R9: A new ratio code takes effect only at the next divided-period boundary of its channel. The interval in progress completes at the old ratio.
- R10: When a stop is released, the channel counter restarts from zero. With a base ratio of 1, the first pulse comes in the N-th master cycle after the releasing edge, where N is the channel ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 base, 1 peripheral, 2 trace, 3 stop bit) |
| cfg_wdata | input | 3 | Write data |
| lp_timer | input | 1 | Timer low-power mode active |
| lp_stop | input | 1 | Stop low-power mode active |
| base_en | output | 1 | Base clock enable pulse |
| pbus_en | output | 1 | Peripheral bus clock enable pulse |
| trace_en | output | 1 | Trace clock enable pulse |

## Verification
The assertions check four things on every cycle:
- the derived enables nest inside base_en;
- they stay silent under a low-power mode or the peripheral stop bit;
- a channel's active ratio changes only right after its own pulse or while that channel is stopped.

The actual periods cannot be seen from one cycle, so only the bench scenarios show them. The same holds for saturation of illegal codes, the full old-ratio interval after a change, and the distance from a release to the first pulse. The bench measures each of these by counting master cycles between pulses.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_BASE  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PBUS  = 2'd1;
  localparam logic [ADDR_W-1:0] A_TRACE = 2'd2;
  localparam logic [ADDR_W-1:0] A_GATE  = 2'd3;

  // log2 of the ratio a code selects, clamped to the channel maximum
  function automatic int unsigned sat_log(input int unsigned code, input int unsigned max_log);
    return (code > max_log) ? max_log : code;
  endfunction

  // last counter value of a period of 2**log2r ticks
  function automatic int unsigned period_last(input int unsigned log2r);
    return (32'd1 << log2r) - 32'd1;
  endfunction
endpackage

// File: rtl/busclk_regs.sv
module busclk_regs
  import busclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              lp_timer,
  input  logic              lp_stop,
  output logic [CODE_W-1:0] base_code,
  output logic [CODE_W-1:0] pbus_code,
  output logic [CODE_W-1:0] trace_code,
  output logic              pbus_gate,
  output logic              sleep
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_code  <= '0;
      pbus_code  <= '0;
      trace_code <= '0;
      pbus_gate  <= 1'b0;
      sleep      <= 1'b0;
    end else begin
      sleep <= lp_timer | lp_stop;
      if (we) begin
        unique case (addr)
          A_BASE:  base_code  <= wdata;
          A_PBUS:  pbus_code  <= wdata;
          A_TRACE: trace_code <= wdata;
          A_GATE:  pbus_gate  <= wdata[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/busclk_div.sv
module busclk_div
  import busclk_pkg::*;
#(
  parameter int unsigned MAX_LOG = 4,
  localparam int unsigned LOG_W  = $clog2(MAX_LOG + 1),
  localparam int unsigned CNT_W  = (MAX_LOG < 1) ? 1 : MAX_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              run,
  input  logic [CODE_W-1:0] code_req,
  output logic              tick_out,
  output logic [LOG_W-1:0]  act_log
);
  logic [CNT_W-1:0] cnt;
  logic [LOG_W-1:0] req_log;
  logic             at_last;

  assign req_log  = LOG_W'(sat_log(int'(code_req), MAX_LOG));
  assign at_last  = (cnt == CNT_W'(period_last(int'(act_log))));
  assign tick_out = run & tick_in & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_log <= '0;
    end else if (!run) begin
      cnt     <= '0;
      act_log <= req_log;
    end else if (tick_in) begin
      if (at_last) begin
        cnt     <= '0;
        act_log <= req_log;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/busclk_gen.sv
module busclk_gen
  import busclk_pkg::*;
#(
  parameter int unsigned BASE_MAX_LOG  = 4,
  parameter int unsigned PBUS_MAX_LOG  = 3,
  parameter int unsigned TRACE_MAX_LOG = 1,
  localparam int unsigned BASE_LW  = $clog2(BASE_MAX_LOG + 1),
  localparam int unsigned PBUS_LW  = $clog2(PBUS_MAX_LOG + 1),
  localparam int unsigned TRACE_LW = $clog2(TRACE_MAX_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              lp_timer,
  input  logic              lp_stop,
  output logic              base_en,
  output logic              pbus_en,
  output logic              trace_en
);
  logic [CODE_W-1:0]   base_code, pbus_code, trace_code;
  logic                pbus_gate, sleep;
  logic                pbus_run, trace_run;
  logic [BASE_LW-1:0]  base_act;
  logic [PBUS_LW-1:0]  pbus_act;
  logic [TRACE_LW-1:0] trace_act;

  assign pbus_run  = ~pbus_gate & ~sleep;
  assign trace_run = ~sleep;

  busclk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lp_timer(lp_timer), .lp_stop(lp_stop),
    .base_code(base_code), .pbus_code(pbus_code), .trace_code(trace_code),
    .pbus_gate(pbus_gate), .sleep(sleep)
  );

  busclk_div #(.MAX_LOG(BASE_MAX_LOG)) u_base (
    .clk(clk), .rst_n(rst_n), .tick_in(1'b1), .run(1'b1),
    .code_req(base_code), .tick_out(base_en), .act_log(base_act)
  );

  busclk_div #(.MAX_LOG(PBUS_MAX_LOG)) u_pbus (
    .clk(clk), .rst_n(rst_n), .tick_in(base_en), .run(pbus_run),
    .code_req(pbus_code), .tick_out(pbus_en), .act_log(pbus_act)
  );

  busclk_div #(.MAX_LOG(TRACE_MAX_LOG)) u_trace (
    .clk(clk), .rst_n(rst_n), .tick_in(base_en), .run(trace_run),
    .code_req(trace_code), .tick_out(trace_en), .act_log(trace_act)
  );
endmodule

// File: rtl/busclk_gen_chk.sv
module busclk_gen_chk #(
  parameter int unsigned BASE_LW  = 3,
  parameter int unsigned PBUS_LW  = 2,
  parameter int unsigned TRACE_LW = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                base_en,
  input logic                pbus_en,
  input logic                trace_en,
  input logic                sleep,
  input logic                pbus_gate,
  input logic                pbus_run,
  input logic                trace_run,
  input logic [BASE_LW-1:0]  base_act,
  input logic [PBUS_LW-1:0]  pbus_act,
  input logic [TRACE_LW-1:0] trace_act
);
  p_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pbus_en || trace_en) |-> base_en);

  p_lowpower_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!pbus_en && !trace_en));

  p_gate_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pbus_gate |-> !pbus_en);

  p_base_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_act) |-> $past(base_en));

  p_pbus_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pbus_act) |-> $past(pbus_en || !pbus_run));

  p_trace_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trace_act) |-> $past(trace_en || !trace_run));
endmodule

bind busclk_gen busclk_gen_chk #(
  .BASE_LW(BASE_LW), .PBUS_LW(PBUS_LW), .TRACE_LW(TRACE_LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .base_en(base_en), .pbus_en(pbus_en),
  .trace_en(trace_en), .sleep(sleep), .pbus_gate(pbus_gate),
  .pbus_run(pbus_run), .trace_run(trace_run), .base_act(base_act),
  .pbus_act(pbus_act), .trace_act(trace_act)
);

// File: tb/busclk_gen_test.sv
`timescale 1ns/1ps
module busclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [2:0] cfg_wdata = '0;
  logic       lp_timer = 1'b0;
  logic       lp_stop = 1'b0;
  logic       base_en, pbus_en, trace_en;
  int         checks = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  busclk_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lp_timer(lp_timer), .lp_stop(lp_stop),
    .base_en(base_en), .pbus_en(pbus_en), .trace_en(trace_en)
  );

  function automatic logic sel_en(input int sel);
    return (sel == 0) ? base_en : (sel == 1) ? pbus_en : trace_en;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // waits at negedges for a pulse; returns cycles waited (capped)
  task automatic wait_pulse(input int sel, output int n);
    n = 0;
    while (!sel_en(sel) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // from a pulse, count master cycles to the next pulse
  task automatic period(input int sel, output int p);
    int w;
    wait_pulse(sel, w);
    @(negedge clk);
    p = 1;
    while (!sel_en(sel) && p < 5000) begin
      @(negedge clk);
      p++;
    end
  endtask

  task automatic settle(input int sel);
    int p;
    period(sel, p);
    period(sel, p);
  endtask

  task automatic t_reset;
    int ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (base_en && pbus_en && trace_en) ones++;
    end
    check("R1 all enables every cycle after reset", ones, 8);
  endtask

  task automatic t_base_ratios;
    int p;
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 3'(c));
      settle(0);
      period(0, p);
      if (c <= 4) check("R2 base period", p, 1 << c);
      else        check("R3 base saturated period", p, 16);
    end
    wr(2'd0, 3'd0);
  endtask

  task automatic t_pbus_ratios;
    int p;
    wr(2'd0, 3'd1);
    wr(2'd1, 3'd2);
    settle(1); period(1, p);
    check("R4 pbus code2 base2", p, 8);
    wr(2'd1, 3'd5);
    settle(1); period(1, p);
    check("R4 pbus code5 saturates", p, 16);
    wr(2'd0, 3'd0);
    wr(2'd1, 3'd3);
    settle(1); period(1, p);
    check("R4 pbus code3 base1", p, 8);
    wr(2'd1, 3'd0);
  endtask

  task automatic t_trace_ratios;
    int p;
    wr(2'd0, 3'd2);
    wr(2'd2, 3'd1);
    settle(2); period(2, p);
    check("R5 trace code1 base4", p, 8);
    wr(2'd0, 3'd0);
    wr(2'd2, 3'd6);
    settle(2); period(2, p);
    check("R5 trace code6 saturates", p, 2);
    wr(2'd2, 3'd0);
    settle(2); period(2, p);
    check("R5 trace code0", p, 1);
  endtask

  task automatic t_nesting;
    int bad = 0;
    wr(2'd0, 3'd2);
    wr(2'd1, 3'd1);
    wr(2'd2, 3'd1);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if ((pbus_en || trace_en) && !base_en) bad++;
    end
    check("R6 derived pulse outside base pulse", bad, 0);
    wr(2'd0, 3'd0); wr(2'd1, 3'd0); wr(2'd2, 3'd0);
  endtask

  task automatic t_gate;
    int pb = 0, tr = 0, p;
    wr(2'd3, 3'd1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pbus_en) pb++;
      if (trace_en) tr++;
    end
    check("R8 pbus silent while stopped", pb, 0);
    check("R8 trace unaffected by stop bit", tr, 40);
    wr(2'd1, 3'd2);
    wr(2'd3, 3'd0);
    p = 1;
    while (!pbus_en && p < 100) begin
      @(negedge clk);
      p++;
    end
    check("R10 first pbus pulse after stop release", p, 4);
    wr(2'd1, 3'd0);
  endtask

  task automatic t_lowpower(input bit use_stop);
    int pb = 0, tr = 0, bs = 0, p;
    wr(2'd0, 3'd1);
    wr(2'd2, 3'd1);
    @(negedge clk);
    if (use_stop) lp_stop = 1'b1; else lp_timer = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pbus_en) pb++;
      if (trace_en) tr++;
      if (base_en) bs++;
    end
    check("R7 pbus silent in low power", pb, 0);
    check("R7 trace silent in low power", tr, 0);
    check("R7 base keeps running", bs, 20);
    wr(2'd0, 3'd0);
    wr(2'd1, 3'd3);
    @(negedge clk);
    lp_timer = 1'b0; lp_stop = 1'b0;
    @(negedge clk);
    p = 1;
    while (!pbus_en && p < 100) begin
      @(negedge clk);
      p++;
    end
    check("R10 first pbus pulse after low-power release", p, 8);
    wr(2'd1, 3'd0);
    wr(2'd2, 3'd0);
  endtask

  task automatic t_boundary;
    int w, n, p;
    wr(2'd0, 3'd0);
    wr(2'd1, 3'd3);
    settle(1);
    wait_pulse(1, w);
    wr(2'd1, 3'd1);
    n = 2;
    while (!pbus_en && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R9 old ratio interval completes", n, 8);
    @(negedge clk);
    p = 1;
    while (!pbus_en && p < 100) begin
      @(negedge clk);
      p++;
    end
    check("R9 new ratio after boundary", p, 2);
    wr(2'd1, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    t_reset();
    t_base_ratios();
    t_pbus_ratios();
    t_trace_ratios();
    t_nesting();
    t_gate();
    t_lowpower(1'b0);
    t_lowpower(1'b1);
    t_boundary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule